// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller with Configuration-Aware Instruction Gating

This block is the test access port of a configurable chip. It follows the sixteen-state test-port state machine, clocked by `tck` and steered by `tms`. It holds a 10-bit instruction register, decodes the current instruction and routes `tdo` from the selected data register. Three data registers live inside the block: a 1-bit bypass register, a 32-bit identification register and a 32-bit user-code register. The boundary register and four user data registers live outside it. For those the block provides a select, capture, shift and update strobe per register and takes back that register's serial output. Two further instructions produce single-cycle start and shutdown strobes for the configuration engine.

Two status inputs gate the instructions. `cfg_done` reports that configuration has finished, and until it is high the four user instructions act as bypass. `cfg_busy` reports that configuration is in progress, and while it is high the three boundary-register instructions act as bypass. The gating reads the status inputs continuously, so a status change takes effect at once on the instruction already held. The chip-level program input `prog_n` is wired in but never touches the controller. Only power-on reset (`por_n`) or a walk into Test-Logic-Reset returns the controller to its initial state.

Top module: `scan_tap_ctrl`

## Requirements
- R1: The state machine makes the sixteen standard transitions on rising `tck`. For example, five cycles with `tms`=1 reach Test-Logic-Reset from any state, and `tms`=0 there moves to Run-Test/Idle.
- R2: Capture-IR loads 10'b0000010001 into the instruction shifter. The shifter moves towards `tdo` LSB first, and its content becomes the instruction on the falling `tck` edge in Update-IR. Codes: EXTEST 0x3C0, SAMPLE 0x3C1, USER1 0x3C2, USER2 0x3C3, INTEST 0x3C7, USERCODE 0x3C8, IDCODE 0x3C9, HIGHZ 0x3CA, JSTART 0x3CC, JSHUTDOWN 0x3CD, USER3 0x3E2, USER4 0x3E3, BYPASS 0x3FF.
- R3: Power-on reset and every cycle in Test-Logic-Reset set the instruction to IDCODE.
- R4: The bypass register is one bit and captures 0. The identification register captures the parameter `ID_VALUE`, and the user-code register captures the `usercode` input. Both are 32 bits and shift LSB first.
- R5: While `cfg_done` is low, USER1 to USER4 act as BYPASS and `usr_sel` is 0.
- R6: While `cfg_busy` is high, EXTEST, INTEST and SAMPLE act as BYPASS and `bsr_sel` is 0, including in the very cycle the status changes.
- R7: An instruction code not listed in R2 acts as BYPASS.
- R8: `tdo` and `tdo_oe` change only on falling `tck`. `tdo_oe` is 1 exactly for the falling edges in Shift-IR or Shift-DR.
- R9: Each external register's capture, shift and update strobes are high in Capture-DR, Shift-DR and Update-DR while its instruction is active. Bit k of the `usr_*` vectors belongs to USER(k+1).
- R10: `cfg_start` (JSTART) and `cfg_stop` (JSHUTDOWN) are high for the first `tck` cycle of each stay in Run-Test/Idle.
- R11: `prog_n` has no effect on state, instruction or outputs.
- R12: `extest_en`, `intest_en` and `highz_en` are high while EXTEST, INTEST or HIGHZ is the active instruction. HIGHZ shifts through the bypass register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select |
| tdi | input | 1 | Serial data in |
| prog_n | input | 1 | Chip program request (ignored by the controller) |
| cfg_done | input | 1 | Configuration finished |
| cfg_busy | input | 1 | Configuration in progress |
| usercode | input | 32 | Value captured by USERCODE |
| bsr_tdo | input | 1 | Serial output of the boundary register |
| usr_tdo | input | 4 | Serial outputs of the user registers |
| tdo | output | 1 | Serial data out |
| tdo_oe | output | 1 | Output enable for `tdo` |
| bsr_sel | output | 1 | Boundary register selected |
| bsr_capture | output | 1 | Boundary capture strobe |
| bsr_shift | output | 1 | Boundary shift strobe |
| bsr_update | output | 1 | Boundary update strobe |
| usr_sel | output | 4 | User register selected |
| usr_capture | output | 4 | User capture strobes |
| usr_shift | output | 4 | User shift strobes |
| usr_update | output | 4 | User update strobes |
| extest_en | output | 1 | External test mode active |
| intest_en | output | 1 | Internal test mode active |
| highz_en | output | 1 | Output-float mode active |
| cfg_start | output | 1 | Configuration start pulse |
| cfg_stop | output | 1 | Configuration shutdown pulse |

## Verification
The case that needs care is a configuration-status change landing in the same `tck` cycle as a data-register capture under a gated instruction. The bench holds EXTEST with `cfg_busy` low and walks into Capture-DR, where `bsr_capture` must be high. Within that same cycle, before the rising edge, it raises `cfg_busy`. The strobe must drop at once, and the following shift must show the bypass register's 0 followed by the shifted-in data, not the boundary register's output. Released user instructions are judged the same way: raising `cfg_done` must select the user register without a new instruction load.

// File: rtl/scan_tap_ctrl.sv
module scan_tap_ctrl #(
  parameter logic [31:0] ID_VALUE = 32'h1A2B_3C4D
) (
  input  logic        tck,
  input  logic        por_n,
  input  logic        tms,
  input  logic        tdi,
  input  logic        prog_n,
  input  logic        cfg_done,
  input  logic        cfg_busy,
  input  logic [31:0] usercode,
  input  logic        bsr_tdo,
  input  logic [3:0]  usr_tdo,
  output logic        tdo,
  output logic        tdo_oe,
  output logic        bsr_sel,
  output logic        bsr_capture,
  output logic        bsr_shift,
  output logic        bsr_update,
  output logic [3:0]  usr_sel,
  output logic [3:0]  usr_capture,
  output logic [3:0]  usr_shift,
  output logic [3:0]  usr_update,
  output logic        extest_en,
  output logic        intest_en,
  output logic        highz_en,
  output logic        cfg_start,
  output logic        cfg_stop
);
  localparam int IRW = 10;
  localparam logic [IRW-1:0] IR_CAPTURE = 10'b0000010001;
  localparam logic [IRW-1:0] I_EXTEST = 10'h3C0, I_SAMPLE = 10'h3C1, I_USER1 = 10'h3C2,
    I_USER2 = 10'h3C3, I_INTEST = 10'h3C7, I_USERCODE = 10'h3C8, I_IDCODE = 10'h3C9,
    I_HIGHZ = 10'h3CA, I_JSTART = 10'h3CC, I_JSHUT = 10'h3CD, I_USER3 = 10'h3E2,
    I_USER4 = 10'h3E3;

  typedef enum logic [3:0] {
    S_TLR, S_RTI, S_SELDR, S_CAPDR, S_SHDR, S_EX1DR, S_PADR, S_EX2DR, S_UPDR,
    S_SELIR, S_CAPIR, S_SHIR, S_EX1IR, S_PAIR, S_EX2IR, S_UPIR
  } tap_t;

  typedef enum logic [3:0] {
    OP_BYP, OP_EXT, OP_INT, OP_SMP, OP_IDC, OP_UC, OP_HIZ,
    OP_U1, OP_U2, OP_U3, OP_U4, OP_JST, OP_JSD
  } op_t;

  tap_t state, nxt;
  op_t  raw, op;
  logic [IRW-1:0] ir, ir_sh;
  logic [31:0] dr32;
  logic byp, was_rti;

  always_comb begin
    case (state)
      S_TLR:   nxt = tms ? S_TLR   : S_RTI;
      S_RTI:   nxt = tms ? S_SELDR : S_RTI;
      S_SELDR: nxt = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: nxt = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  nxt = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: nxt = tms ? S_UPDR  : S_PADR;
      S_PADR:  nxt = tms ? S_EX2DR : S_PADR;
      S_EX2DR: nxt = tms ? S_UPDR  : S_SHDR;
      S_UPDR:  nxt = tms ? S_SELDR : S_RTI;
      S_SELIR: nxt = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: nxt = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  nxt = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: nxt = tms ? S_UPIR  : S_PAIR;
      S_PAIR:  nxt = tms ? S_EX2IR : S_PAIR;
      S_EX2IR: nxt = tms ? S_UPIR  : S_SHIR;
      default: nxt = tms ? S_SELDR : S_RTI;
    endcase
  end

  always_ff @(posedge tck or negedge por_n)
    if (!por_n) begin
      state   <= S_TLR;
      was_rti <= 1'b0;
    end else begin
      state   <= nxt;
      was_rti <= (state == S_RTI);
    end

  always_ff @(posedge tck)
    if (state == S_CAPIR)     ir_sh <= IR_CAPTURE;
    else if (state == S_SHIR) ir_sh <= {tdi, ir_sh[IRW-1:1]};

  always_ff @(negedge tck or negedge por_n)
    if (!por_n)               ir <= I_IDCODE;
    else if (state == S_TLR)  ir <= I_IDCODE;
    else if (state == S_UPIR) ir <= ir_sh;

  always_comb begin
    case (ir)
      I_EXTEST:   raw = OP_EXT;
      I_SAMPLE:   raw = OP_SMP;
      I_INTEST:   raw = OP_INT;
      I_IDCODE:   raw = OP_IDC;
      I_USERCODE: raw = OP_UC;
      I_HIGHZ:    raw = OP_HIZ;
      I_USER1:    raw = OP_U1;
      I_USER2:    raw = OP_U2;
      I_USER3:    raw = OP_U3;
      I_USER4:    raw = OP_U4;
      I_JSTART:   raw = OP_JST;
      I_JSHUT:    raw = OP_JSD;
      default:    raw = OP_BYP;
    endcase
    op = raw;
    if (!cfg_done && (raw inside {OP_U1, OP_U2, OP_U3, OP_U4})) op = OP_BYP;
    if (cfg_busy && (raw inside {OP_EXT, OP_INT, OP_SMP}))      op = OP_BYP;
  end

  wire cap_dr = (state == S_CAPDR);
  wire sh_dr  = (state == S_SHDR);
  wire up_dr  = (state == S_UPDR);

  always_ff @(posedge tck)
    if (cap_dr) begin
      byp <= 1'b0;
      if (op == OP_IDC)     dr32 <= ID_VALUE;
      else if (op == OP_UC) dr32 <= usercode;
    end else if (sh_dr) begin
      byp  <= tdi;
      dr32 <= {tdi, dr32[31:1]};
    end

  assign bsr_sel     = op inside {OP_EXT, OP_INT, OP_SMP};
  assign usr_sel     = {op == OP_U4, op == OP_U3, op == OP_U2, op == OP_U1};
  assign bsr_capture = bsr_sel & cap_dr;
  assign bsr_shift   = bsr_sel & sh_dr;
  assign bsr_update  = bsr_sel & up_dr;
  assign usr_capture = usr_sel & {4{cap_dr}};
  assign usr_shift   = usr_sel & {4{sh_dr}};
  assign usr_update  = usr_sel & {4{up_dr}};
  assign extest_en   = (op == OP_EXT);
  assign intest_en   = (op == OP_INT);
  assign highz_en    = (op == OP_HIZ);

  wire rti_entry = (state == S_RTI) && !was_rti;
  assign cfg_start = rti_entry && (op == OP_JST);
  assign cfg_stop  = rti_entry && (op == OP_JSD);

  logic dr_out;
  always_comb
    case (op)
      OP_IDC, OP_UC:         dr_out = dr32[0];
      OP_EXT, OP_INT, OP_SMP: dr_out = bsr_tdo;
      OP_U1:                 dr_out = usr_tdo[0];
      OP_U2:                 dr_out = usr_tdo[1];
      OP_U3:                 dr_out = usr_tdo[2];
      OP_U4:                 dr_out = usr_tdo[3];
      default:               dr_out = byp;
    endcase

  always_ff @(negedge tck or negedge por_n)
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo    <= (state == S_SHIR) ? ir_sh[0] : dr_out;
      tdo_oe <= (state == S_SHIR) || sh_dr;
    end

  a_r1_tlr_exit: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_TLR && !tms) |=> (state == S_RTI));
  a_r3_tlr_idcode: assert property (@(posedge tck) disable iff (!por_n)
    (state == S_TLR) |=> (ir == I_IDCODE));
  a_r5_user_gate: assert property (@(posedge tck) disable iff (!por_n)
    !cfg_done |-> (usr_sel == 4'b0));
  a_r6_bsr_gate: assert property (@(posedge tck) disable iff (!por_n)
    cfg_busy |-> !(bsr_capture || bsr_shift || bsr_update));
  a_r8_oe_window: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == (state == S_SHIR || state == S_SHDR));
  a_r9_onehot_sel: assert property (@(posedge tck) disable iff (!por_n)
    $onehot0({bsr_sel, usr_sel}));
  a_r10_single_pulse: assert property (@(posedge tck) disable iff (!por_n)
    (cfg_start || cfg_stop) |=> !(cfg_start || cfg_stop));
  a_r11_prog_ignored: assert property (@(posedge tck) disable iff (!por_n)
    (!prog_n && state == S_RTI && !tms) |=> (state == S_RTI));
endmodule

// File: tb/scan_tap_ctrl_test.sv
module scan_tap_ctrl_test;
  localparam logic [31:0] ID = 32'h1A2B_3C4D;
  localparam logic [31:0] UCODE = 32'hC0DE_1234;
  logic tck = 0, por_n = 0, tms = 1, tdi = 0, prog_n = 1;
  logic cfg_done = 0, cfg_busy = 0, bsr_tdo = 1;
  logic [3:0] usr_tdo = 4'b0101;
  logic [31:0] usercode = UCODE;
  logic tdo, tdo_oe, bsr_sel, bsr_capture, bsr_shift, bsr_update;
  logic [3:0] usr_sel, usr_capture, usr_shift, usr_update;
  logic extest_en, intest_en, highz_en, cfg_start, cfg_stop;

  scan_tap_ctrl #(.ID_VALUE(ID)) uut (.*);

  always #5 tck = ~tck;

  typedef struct { string tag; int len; logic [31:0] val; } exp_t;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [31:0] got = '0;
  int cnt = 0;
  always @(posedge tck) if (por_n && tdo_oe) begin
    if (q.size() == 0) chk("R8 unexpected tdo_oe", 1, 0);
    else begin
      got[cnt] = tdo;
      cnt++;
      if (cnt == q[0].len) begin
        chk(q[0].tag, got & ((64'd1 << cnt) - 1), q[0].val & ((64'd1 << cnt) - 1));
        void'(q.pop_front());
        cnt = 0;
        got = '0;
      end
    end
  end

  task automatic step(input logic m, input logic d);
    @(negedge tck); #1; tms = m; tdi = d;
    @(posedge tck); #1;
  endtask

  task automatic shift_bits(input int n, input logic [31:0] d, input string tag, input logic [31:0] e);
    exp_t it;
    it.tag = tag; it.len = n; it.val = e;
    q.push_back(it);
    for (int i = 0; i < n; i++) step(i == n - 1, d[i]);
  endtask

  task automatic load_ir(input logic [9:0] c, input string tag);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    shift_bits(10, {22'd0, c}, {tag, " R2 IR capture"}, 32'h011);
    step(1, 0); step(0, 0);
  endtask

  task automatic scan_dr(input int n, input logic [31:0] d, input string tag, input logic [31:0] e);
    step(1, 0); step(0, 0); step(0, 0);
    shift_bits(n, d, tag, e);
    step(1, 0); step(0, 0);
  endtask

  function automatic logic [31:0] byp_exp(input int n, input logic [31:0] d);
    return (d << 1) & ((64'd1 << n) - 1);
  endfunction

  initial begin
    #1_000_000;
    chk("watchdog expired", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #23 por_n = 1;
    chk("R8 tdo_oe low after reset", tdo_oe, 0);
    chk("R10 no strobe after reset", {cfg_start, cfg_stop}, 0);
    step(0, 0);
    scan_dr(32, 0, "R3 IDCODE after power-on", ID);

    load_ir(10'h3FF, "bypass");
    scan_dr(8, 8'hA5, "R4 bypass captures 0", byp_exp(8, 8'hA5));
    load_ir(10'h3C8, "usercode");
    scan_dr(32, 32'h0, "R4 usercode capture", UCODE);
    load_ir(10'h3C9, "idcode");
    scan_dr(32, 32'hFFFF_FFFF, "R4 idcode capture", ID);

    load_ir(10'h3C2, "user1 blocked");
    chk("R5 usr_sel low before config", usr_sel, 0);
    scan_dr(6, 6'h2D, "R5 blocked user acts as bypass", byp_exp(6, 6'h2D));
    cfg_done = 1; #1;
    chk("R5 user1 selected after config", usr_sel, 4'b0001);
    scan_dr(4, 0, "R5 user1 data path", 4'hF);

    load_ir(10'h3C3, "user2");
    step(1, 0); step(0, 0);
    chk("R9 user2 capture strobe", usr_capture, 4'b0010);
    chk("R9 no boundary capture", bsr_capture, 0);
    step(0, 0);
    chk("R9 user2 shift strobe", usr_shift, 4'b0010);
    shift_bits(3, 0, "R9 user2 data path", 0);
    step(1, 0);
    chk("R9 user2 update strobe", usr_update, 4'b0010);
    step(0, 0);

    cfg_busy = 1;
    load_ir(10'h3C0, "extest busy");
    chk("R6 bsr_sel low while busy", bsr_sel, 0);
    chk("R12 extest off while busy", extest_en, 0);
    scan_dr(5, 5'h13, "R6 blocked boundary acts as bypass", byp_exp(5, 5'h13));
    cfg_busy = 0; #1;
    chk("R6 boundary released", bsr_sel, 1);
    chk("R12 extest_en", extest_en, 1);
    step(1, 0); step(0, 0);
    chk("R9 boundary capture strobe", bsr_capture, 1);
    cfg_busy = 1; #1;
    chk("R6 capture strobe drops same cycle", bsr_capture, 0);
    step(0, 0);
    shift_bits(4, 4'b1011, "R6 busy at capture gives bypass", byp_exp(4, 4'b1011));
    step(1, 0); step(0, 0);
    cfg_busy = 0;

    load_ir(10'h3C1, "sample");
    chk("R12 sample not extest", {bsr_sel, extest_en, intest_en}, 3'b100);
    scan_dr(3, 0, "R6 sample allowed", 3'b111);
    load_ir(10'h3C7, "intest");
    chk("R12 intest_en", {bsr_sel, intest_en}, 2'b11);
    load_ir(10'h3CA, "highz");
    chk("R12 highz_en", {highz_en, bsr_sel}, 2'b10);
    scan_dr(4, 4'h9, "R12 highz uses bypass", byp_exp(4, 4'h9));
    load_ir(10'h155, "unknown");
    chk("R7 unknown selects nothing", {bsr_sel, usr_sel, highz_en}, 0);
    scan_dr(5, 5'h16, "R7 unknown acts as bypass", byp_exp(5, 5'h16));

    load_ir(10'h3CC, "jstart");
    chk("R10 start pulse", {cfg_start, cfg_stop}, 2'b10);
    step(0, 0);
    chk("R10 start pulse one cycle", cfg_start, 0);
    load_ir(10'h3CD, "jshutdown");
    chk("R10 stop pulse", {cfg_start, cfg_stop}, 2'b01);
    step(0, 0);
    chk("R10 stop pulse one cycle", cfg_stop, 0);

    load_ir(10'h3C8, "usercode prog");
    prog_n = 0;
    step(0, 0); step(0, 0);
    scan_dr(32, 0, "R11 program ignored", UCODE);
    prog_n = 1;

    load_ir(10'h3FF, "bypass tlr");
    step(1, 0); step(0, 0); step(1, 0); step(0, 0);
    #5 chk("R8 tdo_oe low in Pause-DR", tdo_oe, 0);
    step(1, 0); step(1, 0);
    step(1, 0); step(1, 0); step(1, 0);
    step(0, 0);
    scan_dr(32, 0, "R1 R3 Test-Logic-Reset restores IDCODE", ID);

    step(0, 0); step(0, 0);
    chk("scoreboard drained", q.size(), 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule